// File: doc/BRIEF.md
# Pipelined Reciprocal Lookup Unit

The unit gives a fast approximation of the inverse of a signed fixed-point word. It takes an input sample and shifts it arithmetically right by a fixed amount. It keeps the low address bits of the result and uses them to index a read-only table. The table holds rounded values of 2^SCALE divided by (index + OFFSET), and its contents are computed from parameters when the design is elaborated.

The selected entry passes through two register stages: a table read register and an output register. A new input can be applied every cycle, and each result appears a fixed two edges later. The result is a signed word of DATA_W bits.

The asynchronous reset clears only the output register. The table and the read stage keep running while reset is asserted.

Top module: `recip_lut`

## Requirements
- R1: The table index is (in_i >>> SHIFT) & MASK when SHIFT > 0, where MASK = 2^ADDR_W - 1 and the table holds 2^ADDR_W entries; a negative input therefore indexes with the low bits of its two's-complement shifted value.
- R2: When SHIFT is 0, the index is in_i & MASK.
- R3: Entry a holds round(2^SCALE / (a + OFFSET)), rounded half up.
- R4: An entry whose divisor a + OFFSET is zero or negative holds the largest positive value of DATA_W bits, 2^(DATA_W-1) - 1.
- R5: An entry keeps only the low DATA_W bits of its ideal value, and out_o reads those bits as a signed two's-complement number, so an ideal value of 2^(DATA_W-1) or more wraps.
- R6: An input present at rising edge t appears on out_o right after rising edge t+1, and a new input is accepted on every cycle.
- R7: While rst_ni is low, out_o is 0 at once; the read stage keeps loading, so the first output after release comes from the input held during reset.
- R8: The table is read-only, so an input held steady gives a steady output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| in_i | input | IN_W | Signed input word |
| out_o | output | DATA_W | Signed approximate reciprocal |

## Verification
Each result is due two rising edges after its input is sampled: one edge loads the read register and the next loads the output register. The bench drives inputs and samples outputs on falling edges. When it streams inputs, it compares the output at each falling edge with the vector applied two falling edges earlier. The directed tests check the output after one edge, to show it still holds the old value, and again after two edges. After reset is released, the output is due on the first edge, because the read stage was loaded during reset.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Ideal table value before truncation to the data width
  function automatic longint recip_ideal(input longint idx, input int scale,
                                         input int offset, input int data_w);
    longint div;
    div = idx + longint'(offset);
    if (div <= 0) return (longint'(1) << (data_w - 1)) - 1;
    return ((longint'(1) << scale) + (div / 2)) / div;
  endfunction

endpackage

// File: rtl/recip_addr_gen.sv
module recip_addr_gen #(
  parameter int IN_W   = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 8
) (
  input  logic signed [IN_W-1:0]   in_i,
  output logic        [ADDR_W-1:0] addr_o
);
  localparam logic [IN_W-1:0] MASK = IN_W'((1 << ADDR_W) - 1);

  logic signed [IN_W-1:0] shifted;

  generate
    if (SHIFT > 0) begin : g_shift
      assign shifted = in_i >>> SHIFT;
    end else begin : g_noshift
      assign shifted = in_i;
    end
  endgenerate

  logic [IN_W-1:0] masked;
  assign masked = shifted & MASK;
  assign addr_o = masked[ADDR_W-1:0];
endmodule

// File: rtl/recip_rom.sv
module recip_rom
  import recip_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int SCALE  = 16,
  parameter int OFFSET = 0
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] tbl [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      localparam longint IDEAL = recip_ideal(longint'(g), SCALE, OFFSET, DATA_W);
      localparam logic [63:0] BITS = 64'(IDEAL);
      assign tbl[g] = BITS[DATA_W-1:0];
    end
  endgenerate

  // read register: not reset, keeps running during reset
  always_ff @(posedge clk_i) rd_o <= tbl[addr_i];
endmodule

// File: rtl/recip_out_reg.sv
module recip_out_reg #(
  parameter int DATA_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic        [DATA_W-1:0] d_i,
  output logic signed [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= $signed(d_i);
  end
endmodule

// File: rtl/recip_lut.sv
module recip_lut #(
  parameter int IN_W   = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int SCALE  = 16,
  parameter int OFFSET = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [IN_W-1:0]   in_i,
  output logic signed [DATA_W-1:0] out_o
);
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] rd_w;

  recip_addr_gen #(.IN_W(IN_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_addr (
    .in_i  (in_i),
    .addr_o(addr_w)
  );

  recip_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCALE(SCALE), .OFFSET(OFFSET)) u_rom (
    .clk_i (clk_i),
    .addr_i(addr_w),
    .rd_o  (rd_w)
  );

  recip_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_w),
    .q_o   (out_o)
  );
endmodule

// File: rtl/recip_lut_chk.sv
module recip_lut_chk #(
  parameter int IN_W   = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int OFFSET = 0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic signed [IN_W-1:0]   in_i,
  input logic signed [DATA_W-1:0] out_o,
  input logic        [ADDR_W-1:0] addr,
  input logic        [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  assert_reset_clear_R7: assert property (@(posedge clk_i)
    !rst_ni |-> out_o == '0);

  assert_out_follows_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> out_o == $signed($past(rd_data)));

  assert_zero_index_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OFFSET == 0 && $past(addr) == '0) |-> rd_data == MAX_POS);

  assert_read_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(addr) == $past(addr, 2)) |-> $stable(rd_data));

  assert_out_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2) && $past(in_i, 2) == $past(in_i, 3))
      |-> $stable(out_o));
endmodule

bind recip_lut recip_lut_chk #(
  .IN_W(IN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .in_i   (in_i),
  .out_o  (out_o),
  .addr   (addr_w),
  .rd_data(rd_w)
);

// File: tb/sim_recip_lut.sv
`timescale 1ns/1ps
module sim_recip_lut;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [15:0] din = '0;
  logic signed [17:0] dout;
  logic signed [7:0]  din1 = '0;
  logic signed [11:0] dout1;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  recip_lut u0 (.clk_i(clk), .rst_ni(rst_ni), .in_i(din), .out_o(dout));

  recip_lut #(.IN_W(8), .SHIFT(0), .ADDR_W(4), .DATA_W(12), .SCALE(12), .OFFSET(0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(din1), .out_o(dout1));

  localparam int NV = 13;
  localparam logic [15:0] VIN [NV] = '{16'h0010, 16'h0020, 16'h0030, 16'h0000, 16'h000F,
    16'hFFF0, 16'h0FF0, 16'h1010, 16'h00A0, 16'h0070, 16'h8000, 16'h0050, 16'h0060};
  localparam int VEXP [NV] = '{65536, 32768, 21845, 131071, 131071,
    257, 257, 65536, 6554, 9362, 131071, 13107, 10923};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset u0", dout, 0);
    chk("R7 reset u1", dout1, 0);
    rst_ni = 1'b1;

    // streamed vectors: result due two falling edges after drive (R1 R3 R4 R6)
    for (int j = 0; j < NV + 2; j++) begin
      @(negedge clk);
      if (j >= 2) chk("R1 R3 R6 stream", dout, VEXP[j-2]);
      if (j < NV) din = VIN[j];
    end

    // latency: one edge later still old value, two edges later new (R6)
    din = 16'h0010;
    repeat (3) @(negedge clk);
    chk("R6 settle", dout, 65536);
    din = 16'h00A0;
    @(negedge clk);
    chk("R6 one edge old", dout, 65536);
    @(negedge clk);
    chk("R6 two edges new", dout, 6554);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 steady", dout, 6554);
    end

    // reset clears output only; read stage keeps loading (R7)
    din = 16'h0030;
    repeat (2) @(negedge clk);
    chk("R7 pre", dout, 21845);
    rst_ni = 1'b0;
    #1;
    chk("R7 async clear", dout, 0);
    din = 16'h0070;
    repeat (2) @(negedge clk);
    chk("R7 held", dout, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 first after release", dout, 9362);

    // no-shift variant with 12-bit wrapping data (R2 R4 R5)
    din1 = 8'sh01; repeat (2) @(negedge clk);
    chk("R5 wrap to zero", dout1, 0);
    din1 = 8'sh02; repeat (2) @(negedge clk);
    chk("R5 wrap negative", dout1, -2048);
    din1 = 8'sh13; repeat (2) @(negedge clk);
    chk("R2 mask", dout1, 1365);
    din1 = 8'sh00; repeat (2) @(negedge clk);
    chk("R4 zero index", dout1, 2047);
    din1 = -8'sd15; repeat (2) @(negedge clk);
    chk("R2 negative mask", dout1, 0);
    din1 = 8'sh04; repeat (2) @(negedge clk);
    chk("R2 R3 index 4", dout1, 1024);

    done = 1'b1;
    finish_run();
  end
endmodule